// File: doc/BRIEF.md
# Timewheel Watchdog Timer

This block is a watchdog that runs entirely on a slow, free-running low-speed clock of about 1 kHz. After an arm strobe, a timewheel counter advances on every slow-clock edge. Each time it completes the selected period, a small tick counter steps by one. If software does not send a clear strobe before the tick counter would reach three, the block raises a one-cycle reset request. It also sets a reset-cause flag that only power-on reset removes.

A clear zeroes only the tick counter and leaves the timewheel phase untouched. The real timeout after the last clear is therefore between two and three periods. Arming is one-way: once armed, the block cannot be disarmed, and its period and low-power behaviour cannot be changed. A low-power indicator can stretch the period to the longest one or freeze counting, depending on the code latched at arm time. If the slow clock stops, the block stops advancing.

The control state machine has four states:
- `ST_OFF`: disarmed.
- `ST_RUN`: counting.
- `ST_PAUSE`: frozen by the low-power indicator.
- `ST_FIRE`: the one cycle in which the reset request is high.

Its transitions are:
- arm accept: `ST_OFF` to `ST_RUN`, or to `ST_PAUSE` if the stop code is given while the indicator is high.
- expire: any armed state to `ST_FIRE`.
- pause enter: to `ST_PAUSE`.
- pause leave / fire done: to `ST_RUN`.

Top module: `tw_watchdog`

## Requirements
- R1: After power-on reset the block is disarmed, `wdt_req_o` and `wdt_cause_o` are 0, and no request is ever issued while disarmed, whatever `kick_i` does.
- R2: `arm_period_i` selects the period in slow-clock cycles: 0 gives 2, 1 gives 16, 2 gives 128 and 3 gives 1024. The timewheel restarts at zero on the accepted arm edge, and a period event occurs on each edge at which the timewheel completes a whole period.
- R3: With no clear, the request goes high for exactly one cycle after the edge of the third period event. With an arm-only start, that is edge 3·P counted from the arm edge.
- R4: `kick_i` zeroes the tick count but not the timewheel. After a clear at edge K, the request follows the edge (floor(K/P)+3)·P.
- R5: A clear on the same edge as the period event that would be the third one suppresses that request.
- R6: Once armed, further arm strobes are ignored. Period, low-power code and counting phase are all kept.
- R7: `arm_lp_i` code 0 (and the unused code 3) ignores `lowpwr_i`. Code 1 uses the 1024-cycle period while `lowpwr_i` is high. Code 2 freezes the timewheel and tick count while `lowpwr_i` is high.
- R8: `wdt_cause_o` rises together with the request and stays high until power-on reset.
- R9: After a request the tick count restarts at zero and the timewheel keeps running, so an uncleared watchdog requests again every 3·P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow | input | 1 | Slow low-speed counting clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| arm_i | input | 1 | Arm strobe; latches period and low-power code |
| arm_period_i | input | 2 | Period select code (R2) |
| arm_lp_i | input | 2 | Low-power handling code (R7) |
| kick_i | input | 1 | Single-cycle clear strobe |
| lowpwr_i | input | 1 | Low-power mode indicator |
| wdt_req_o | output | 1 | One-cycle reset request pulse |
| wdt_cause_o | output | 1 | Sticky watchdog reset-cause flag |

## Verification
The hardest situation to reach from the ports is a clear that lands exactly on the edge of the would-be third period event. That edge depends on a timewheel phase that cannot be observed. The arm strobe zeroes the timewheel, so the bench counts slow-clock edges from the accepted arm edge and places the clear on edge 48 with a 16-cycle period. It then expects the request to move out to edge 96. The low-power freeze is reached the same way: the indicator is held high for a known number of edges after arming, and the whole request is expected to shift by that count.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2,
        ST_FIRE  = 2'd3
    } wdt_state_e;

    typedef enum logic [1:0] {
        LP_KEEP    = 2'd0,
        LP_LONGEST = 2'd1,
        LP_STOP    = 2'd2,
        LP_UNUSED  = 2'd3
    } lp_mode_e;

endpackage

// File: rtl/wdt_timewheel.sv
`timescale 1ns/1ps
module wdt_timewheel #(
    parameter int BASE_LOG2 = 1,
    parameter int STEP_LOG2 = 3,
    parameter int SEL_W     = 2,
    parameter int TW_BITS   = 10
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               restart,
    input  logic               run_en,
    input  logic [SEL_W-1:0]   sel,
    output logic [TW_BITS-1:0] tw,
    output logic               period_ev
);
    localparam int N_SEL = 1 << SEL_W;

    logic [N_SEL-1:0] wrap_vec;

    // one wrap tap per selectable period: the low LOG2 bits all set
    generate
        for (genvar g = 0; g < N_SEL; g++) begin : g_tap
            localparam int LOG2 = BASE_LOG2 + g * STEP_LOG2;
            assign wrap_vec[g] = &tw[LOG2-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tw <= '0;
        end else if (restart) begin
            tw <= '0;
        end else if (run_en) begin
            tw <= tw + 1'b1;
        end
    end

    assign period_ev = run_en & wrap_vec[sel];

endmodule

// File: rtl/wdt_tickcnt.sv
`timescale 1ns/1ps
module wdt_tickcnt #(
    parameter int LIMIT = 3,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             restart,
    input  logic             kick,
    input  logic             period_ev,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    // a clear on the same edge wins over the final event
    assign expire = period_ev & ~kick & (cnt == CNT_W'(LIMIT - 1));

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (restart || kick || expire) begin
            cnt <= '0;
        end else if (period_ev) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_ctrl.sv
`timescale 1ns/1ps
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             arm,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [1:0]       lp_in,
    input  logic             lp_active,
    input  logic             expire,
    output logic             restart,
    output logic             run_en,
    output logic [SEL_W-1:0] eff_sel,
    output logic             rst_req,
    output logic             cause,
    output logic             armed,
    output logic [SEL_W-1:0] per_q,
    output lp_mode_e         lp_q
);
    localparam logic [SEL_W-1:0] LONG_SEL = '1;

    wdt_state_e state_q, state_d;
    logic       accept;
    logic       pause_now;
    logic       pause_at_arm;

    assign accept       = arm && (state_q == ST_OFF);
    assign pause_now    = (lp_q == LP_STOP) && lp_active;
    assign pause_at_arm = (lp_mode_e'(lp_in) == LP_STOP) && lp_active;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (accept) begin
                    state_d = pause_at_arm ? ST_PAUSE : ST_RUN;
                end
            end
            ST_RUN, ST_PAUSE, ST_FIRE: begin
                if (expire) begin
                    state_d = ST_FIRE;
                end else if (pause_now) begin
                    state_d = ST_PAUSE;
                end else begin
                    state_d = ST_RUN;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // settings latched once at arm, and the sticky cause flag
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            per_q <= '0;
            lp_q  <= LP_KEEP;
            cause <= 1'b0;
        end else begin
            if (accept) begin
                per_q <= sel_in;
                lp_q  <= lp_mode_e'(lp_in);
            end
            if (expire) begin
                cause <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        armed   = (state_q != ST_OFF);
        restart = accept;
        run_en  = armed && !pause_now;
        rst_req = (state_q == ST_FIRE);
        eff_sel = ((lp_q == LP_LONGEST) && lp_active) ? LONG_SEL : per_q;
    end

endmodule

// File: rtl/tw_watchdog.sv
`timescale 1ns/1ps
module tw_watchdog #(
    parameter int BASE_LOG2  = 1,
    parameter int STEP_LOG2  = 3,
    parameter int SEL_W      = 2,
    parameter int TICK_LIMIT = 3
) (
    input  logic             clk_slow,
    input  logic             por_n,
    input  logic             arm_i,
    input  logic [SEL_W-1:0] arm_period_i,
    input  logic [1:0]       arm_lp_i,
    input  logic             kick_i,
    input  logic             lowpwr_i,
    output logic             wdt_req_o,
    output logic             wdt_cause_o
);
    import wdt_pkg::*;

    localparam int N_SEL   = 1 << SEL_W;
    localparam int TW_BITS = BASE_LOG2 + (N_SEL - 1) * STEP_LOG2;
    localparam int CNT_W   = $clog2(TICK_LIMIT + 1);

    logic               restart_w;
    logic               run_en_w;
    logic [SEL_W-1:0]   eff_sel_w;
    logic [TW_BITS-1:0] tw_w;
    logic               period_ev_w;
    logic [CNT_W-1:0]   tick_cnt_w;
    logic               expire_w;
    logic               armed_w;
    logic [SEL_W-1:0]   per_q_w;
    lp_mode_e           lp_q_e;
    logic [1:0]         lp_q_w;

    assign lp_q_w = lp_q_e;

    wdt_ctrl #(
        .SEL_W(SEL_W)
    ) u_ctrl (
        .clk      (clk_slow),
        .por_n    (por_n),
        .arm      (arm_i),
        .sel_in   (arm_period_i),
        .lp_in    (arm_lp_i),
        .lp_active(lowpwr_i),
        .expire   (expire_w),
        .restart  (restart_w),
        .run_en   (run_en_w),
        .eff_sel  (eff_sel_w),
        .rst_req  (wdt_req_o),
        .cause    (wdt_cause_o),
        .armed    (armed_w),
        .per_q    (per_q_w),
        .lp_q     (lp_q_e)
    );

    wdt_timewheel #(
        .BASE_LOG2(BASE_LOG2),
        .STEP_LOG2(STEP_LOG2),
        .SEL_W    (SEL_W),
        .TW_BITS  (TW_BITS)
    ) u_wheel (
        .clk      (clk_slow),
        .por_n    (por_n),
        .restart  (restart_w),
        .run_en   (run_en_w),
        .sel      (eff_sel_w),
        .tw       (tw_w),
        .period_ev(period_ev_w)
    );

    wdt_tickcnt #(
        .LIMIT(TICK_LIMIT),
        .CNT_W(CNT_W)
    ) u_ticks (
        .clk      (clk_slow),
        .por_n    (por_n),
        .restart  (restart_w),
        .kick     (kick_i),
        .period_ev(period_ev_w),
        .cnt      (tick_cnt_w),
        .expire   (expire_w)
    );

endmodule

module wdt_checker #(
    parameter int TICK_LIMIT = 3,
    parameter int CNT_W      = 2,
    parameter int SEL_W      = 2,
    parameter int TW_BITS    = 10
) (
    input logic               clk,
    input logic               por_n,
    input logic               kick,
    input logic               lowpwr,
    input logic               req,
    input logic               cause,
    input logic               armed,
    input logic [CNT_W-1:0]   tick_cnt,
    input logic [SEL_W-1:0]   per_q,
    input logic [1:0]         lp_q,
    input logic [TW_BITS-1:0] tw
);
    a_r1_quiet_disarmed: assert property (@(posedge clk) disable iff (!por_n)
        !armed |=> !req);

    a_r3_req_single: assert property (@(posedge clk) disable iff (!por_n)
        req |=> !req);

    a_r3_tick_bound: assert property (@(posedge clk) disable iff (!por_n)
        tick_cnt < CNT_W'(TICK_LIMIT));

    a_r5_kick_blocks_req: assert property (@(posedge clk) disable iff (!por_n)
        (armed && kick) |=> !req);

    a_r6_arm_locked: assert property (@(posedge clk) disable iff (!por_n)
        armed |=> armed);

    a_r6_period_frozen: assert property (@(posedge clk) disable iff (!por_n)
        armed |=> $stable(per_q) && $stable(lp_q));

    a_r7_pause_freezes: assert property (@(posedge clk) disable iff (!por_n)
        (armed && lp_q == 2'd2 && lowpwr) |=> $stable(tw) && $stable(tick_cnt));

    a_r8_req_sets_cause: assert property (@(posedge clk) disable iff (!por_n)
        req |-> cause);

    a_r8_cause_sticky: assert property (@(posedge clk) disable iff (!por_n)
        cause |=> cause);

    a_r9_restart_after_req: assert property (@(posedge clk) disable iff (!por_n)
        req |-> tick_cnt == '0);

endmodule

bind tw_watchdog wdt_checker #(
    .TICK_LIMIT(TICK_LIMIT),
    .CNT_W     (CNT_W),
    .SEL_W     (SEL_W),
    .TW_BITS   (TW_BITS)
) u_chk (
    .clk     (clk_slow),
    .por_n   (por_n),
    .kick    (kick_i),
    .lowpwr  (lowpwr_i),
    .req     (wdt_req_o),
    .cause   (wdt_cause_o),
    .armed   (armed_w),
    .tick_cnt(tick_cnt_w),
    .per_q   (per_q_w),
    .lp_q    (lp_q_w),
    .tw      (tw_w)
);

// File: tb/tw_watchdog_test.sv
`timescale 1ns/1ps
module tw_watchdog_test;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       arm_i = 1'b0;
    logic [1:0] arm_period_i = '0;
    logic [1:0] arm_lp_i = '0;
    logic       kick_i = 1'b0;
    logic       lowpwr_i = 1'b0;
    logic       wdt_req_o;
    logic       wdt_cause_o;

    int vectors = 0;
    int errors  = 0;
    int edge_n  = 0;

    always #2 clk = ~clk;

    tw_watchdog uut (
        .clk_slow    (clk),
        .por_n       (por_n),
        .arm_i       (arm_i),
        .arm_period_i(arm_period_i),
        .arm_lp_i    (arm_lp_i),
        .kick_i      (kick_i),
        .lowpwr_i    (lowpwr_i),
        .wdt_req_o   (wdt_req_o),
        .wdt_cause_o (wdt_cause_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_por();
        @(negedge clk);
        por_n = 1'b0; arm_i = 1'b0; kick_i = 1'b0; lowpwr_i = 1'b0;
        arm_period_i = '0; arm_lp_i = '0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    // arm over one edge; edge_n counts edges after it
    task automatic do_arm(input logic [1:0] sel, input logic [1:0] code);
        arm_i = 1'b1; arm_period_i = sel; arm_lp_i = code;
        @(negedge clk);
        arm_i = 1'b0;
        edge_n = 0;
    endtask

    // run until the request is seen; strobes placed on given edge numbers
    task automatic watch(input int kick_at, input int lp_drop_at, input int rearm_at,
                         input logic [1:0] rsel, input logic [1:0] rcode,
                         input int limit, output int fired);
        fired = -1;
        while (fired < 0 && edge_n < limit) begin
            kick_i = (edge_n + 1 == kick_at);
            arm_i  = (edge_n + 1 == rearm_at);
            if (arm_i) begin
                arm_period_i = rsel; arm_lp_i = rcode;
            end
            @(negedge clk);
            edge_n++;
            if (edge_n == lp_drop_at) lowpwr_i = 1'b0;
            if (wdt_req_o) fired = edge_n;
        end
        kick_i = 1'b0;
        arm_i  = 1'b0;
    endtask

    task automatic t_reset();
        int f;
        apply_por();
        chk("R1 req after por", wdt_req_o, 0);
        chk("R1 cause after por", wdt_cause_o, 0);
        edge_n = 0;
        // kicks and idle while disarmed
        watch(5, -1, -1, 2'd0, 2'd0, 200, f);
        chk("R1 no request while disarmed", f, -1);
        chk("R1 cause still clear", wdt_cause_o, 0);
    endtask

    task automatic t_period(input logic [1:0] sel, input int per);
        int f;
        apply_por();
        do_arm(sel, 2'd0);
        watch(-1, -1, -1, 2'd0, 2'd0, 3 * per + 10, f);
        chk("R2 R3 first request edge", f, 3 * per);
        chk("R8 cause set with request", wdt_cause_o, 1);
        @(negedge clk);
        edge_n++;
        chk("R3 request lasts one cycle", wdt_req_o, 0);
    endtask

    task automatic t_repeat();
        int f;
        apply_por();
        do_arm(2'd0, 2'd0);
        watch(-1, -1, -1, 2'd0, 2'd0, 20, f);
        chk("R9 first request", f, 6);
        watch(-1, -1, -1, 2'd0, 2'd0, 30, f);
        chk("R9 second request", f, 12);
    endtask

    task automatic t_kick();
        int f;
        apply_por();
        do_arm(2'd1, 2'd0);
        watch(40, -1, -1, 2'd0, 2'd0, 200, f);
        chk("R4 clear keeps timewheel phase", f, 80);
    endtask

    task automatic t_kick_coincide();
        int f;
        apply_por();
        do_arm(2'd1, 2'd0);
        watch(48, -1, -1, 2'd0, 2'd0, 200, f);
        chk("R5 clear on third event wins", f, 96);
    endtask

    task automatic t_rearm();
        int f;
        apply_por();
        do_arm(2'd0, 2'd0);
        lowpwr_i = 1'b1;
        watch(-1, -1, 3, 2'd3, 2'd2, 100, f);
        chk("R6 second arm ignored", f, 6);
        lowpwr_i = 1'b0;
    endtask

    task automatic t_lp_keep(input logic [1:0] code);
        int f;
        apply_por();
        lowpwr_i = 1'b1;
        do_arm(2'd1, code);
        watch(-1, -1, -1, 2'd0, 2'd0, 100, f);
        chk("R7 keep code ignores low power", f, 48);
        lowpwr_i = 1'b0;
    endtask

    task automatic t_lp_longest();
        int f;
        apply_por();
        lowpwr_i = 1'b1;
        do_arm(2'd0, 2'd1);
        watch(-1, -1, -1, 2'd0, 2'd0, 3200, f);
        chk("R7 longest period in low power", f, 3072);
        apply_por();
        do_arm(2'd0, 2'd1);
        watch(-1, -1, -1, 2'd0, 2'd0, 100, f);
        chk("R7 longest code without low power", f, 6);
    endtask

    task automatic t_lp_stop();
        int f;
        apply_por();
        lowpwr_i = 1'b1;
        do_arm(2'd0, 2'd2);
        watch(-1, 50, -1, 2'd0, 2'd0, 200, f);
        chk("R7 stop code freezes counting", f, 56);
    endtask

    task automatic t_cause();
        int f;
        apply_por();
        do_arm(2'd0, 2'd0);
        watch(-1, -1, -1, 2'd0, 2'd0, 20, f);
        repeat (20) @(negedge clk);
        chk("R8 cause stays set", wdt_cause_o, 1);
        apply_por();
        chk("R8 cause cleared by por", wdt_cause_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_period(2'd0, 2);
        t_period(2'd1, 16);
        t_period(2'd2, 128);
        t_period(2'd3, 1024);
        t_repeat();
        t_kick();
        t_kick_coincide();
        t_rearm();
        t_lp_keep(2'd0);
        t_lp_keep(2'd3);
        t_lp_longest();
        t_lp_stop();
        t_cause();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule